// File: doc/BRIEF.md
# Dual-Clock FIFO with Quadrant Direction Flags

This block carries a stream of fixed-width words from one clock domain into another, unrelated one. The producer presents a word with a write request on its own clock and holds off while `wr_full` is high. The consumer raises a read request on its own clock while `rd_empty` is low, and the word appears on `rd_data` one read-clock cycle later. The storage holds 2^ADDR_W words in a simple dual-port array that maps onto block RAM.

Each side keeps a binary address counter and a Gray-coded copy of it. The Gray copy is passed through two flip-flops into the other domain. The pointers carry no extra wrap bit, so equal pointers can mean either an empty or a full FIFO. Each domain settles this with a direction flag that watches the pointers' quadrant, which is the top two Gray bits. The flag is set when the write side trails the read side by one quadrant and cleared when it leads by one. Both flags are registered from the next pointer value and the synchronised far pointer. A flag therefore asserts in the very cycle that fills or drains the array, and releases a few cycles after the other side has acted.

Within any span in which a side's pointer moves by more than a quarter of the depth, the other clock must tick at least once. This means neither clock may run more than DEPTH/4 times faster than the other.

Top module: `async_fifo_qdir`

## Requirements
- R1: A synchronous reset, held for at least two cycles of each clock, leaves `rd_empty` = 1 and `wr_full` = 0. The first word written after reset is the first word read.
- R2: Words leave in the order they were accepted, with none lost or repeated. The word taken by a read accepted at a `rd_clk` edge is on `rd_data` right after that edge.
- R3: When the write side has a settled view of the read pointer, `wr_full` rises at the same `wr_clk` edge that accepts the write filling the last free location. There is no synchroniser delay on that assertion.
- R4: A write request while `wr_full` = 1 is ignored. The write pointer does not move and no stored word changes.
- R5: `rd_empty` rises at the same `rd_clk` edge that accepts the read of the last stored word. A read request while `rd_empty` = 1 is ignored: the read pointer and `rd_data` keep their values.
- R6: Each Gray pointer changes at most one bit per clock cycle of its own domain.
- R7: Quadrants are ordered by top two Gray bits 00, 01, 11, 10 (cyclic). A domain's direction flag is set when the write quadrant is one step behind the read quadrant and cleared when it is one step ahead. `wr_full` may be high only while the write-domain flag is set, and `rd_empty` may be high only while the read-domain flag is clear.
- R8: After the other side frees or fills a location, `wr_full` and `rd_empty` are released within 10 cycles of their own clock.
- R9: Under sustained, concurrent traffic at unrelated clock rates, over many trips around the address ring, the read stream equals the accepted write stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Active-high reset, synchronous to `wr_clk` |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free location, registered in the write domain |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Active-high reset, synchronous to `rd_clk` |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word taken by the last accepted read, registered |
| rd_empty | output | 1 | Nothing stored, registered in the read domain |

## Verification
The bench first fills the array exactly and drains it exactly, because equal pointers are where a wrong direction flag shows up. A design that mis-set the flag would report empty when full, and would then overwrite live data, or report full when empty, and would then deadlock. It repeats writes into a full array and reads from an empty one. An unguarded pointer would then wrap and repeat or lose a whole ring's worth of words. It also checks that each flag rises in the same cycle as the access that fills or drains the array, not after the synchroniser delay, and that each flag is released within a bounded number of cycles. A long run at 20 ns against 26 ns clocks, with irregular gaps, wraps the ring many times, so a quadrant test with the wrong polarity or order would eventually corrupt the stream.

// File: rtl/afq_pkg.sv
package afq_pkg;

  // Quadrant ordinal 0..3 in ring order
  typedef logic [1:0] quad_t;

  // Which way the fill level was last heading
  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } dir_e;

  // Top two Gray bits run 00,01,11,10 around the ring; map them to 0,1,2,3
  function automatic quad_t quad_ord(input logic [1:0] gtop);
    return {gtop[1], gtop[1] ^ gtop[0]};
  endfunction

  // True when quadrant a sits exactly one step after quadrant b
  function automatic logic quad_next_of(input quad_t a, input quad_t b);
    return a == quad_t'(b + 2'd1);
  endfunction

endpackage

// File: rtl/afq_sync.sv
module afq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/afq_mem.sv
module afq_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port, no reset, so it maps onto block RAM output latches
  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/afq_side.sv
module afq_side
  import afq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit WRITE_SIDE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] far_gray,
  output logic [ADDR_W-1:0] bin,
  output logic [ADDR_W-1:0] gray,
  output logic              adv,
  output dir_e              dir,
  output logic              flag
);

  logic [ADDR_W-1:0] bin_nx;
  logic [ADDR_W-1:0] gray_nx;
  quad_t             q_own;
  quad_t             q_far;
  logic              own_behind;
  logic              own_ahead;
  logic              ptr_match;
  dir_e              dir_nx;
  logic              flag_nx;

  // A request is taken only while the blocking flag is low
  assign adv     = req & ~flag;
  assign bin_nx  = bin + ADDR_W'(adv);
  assign gray_nx = bin_nx ^ (bin_nx >> 1);

  assign q_own      = quad_ord(gray_nx[ADDR_W-1 -: 2]);
  assign q_far      = quad_ord(far_gray[ADDR_W-1 -: 2]);
  assign own_behind = quad_next_of(q_far, q_own);
  assign own_ahead  = quad_next_of(q_own, q_far);
  assign ptr_match  = (gray_nx == far_gray);

  generate
    if (WRITE_SIDE) begin : g_wr
      // Own pointer is the writer: trailing the reader means filling up
      always_comb begin
        dir_nx = dir;
        if (own_behind)     dir_nx = DIR_FILL;
        else if (own_ahead) dir_nx = DIR_DRAIN;
      end
      assign flag_nx = ptr_match && (dir_nx == DIR_FILL);
    end else begin : g_rd
      // Own pointer is the reader: the writer trails us when we lead
      always_comb begin
        dir_nx = dir;
        if (own_ahead)       dir_nx = DIR_FILL;
        else if (own_behind) dir_nx = DIR_DRAIN;
      end
      assign flag_nx = ptr_match && (dir_nx == DIR_DRAIN);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
      dir  <= DIR_DRAIN;
      flag <= !WRITE_SIDE;
    end else begin
      bin  <= bin_nx;
      gray <= gray_nx;
      dir  <= dir_nx;
      flag <= flag_nx;
    end
  end

endmodule

// File: rtl/async_fifo_qdir.sv
module async_fifo_qdir
  import afq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4   // at least 2, so that four quadrants exist
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int SYNC_STAGES = 2;

  logic [ADDR_W-1:0] w_bin, w_gray, w_gray_s;
  logic [ADDR_W-1:0] r_bin, r_gray, r_gray_s;
  logic              w_adv, r_adv;
  dir_e              w_dir, r_dir;

  afq_side #(.ADDR_W(ADDR_W), .WRITE_SIDE(1'b1)) u_wside (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .req      (wr_en),
    .far_gray (r_gray_s),
    .bin      (w_bin),
    .gray     (w_gray),
    .adv      (w_adv),
    .dir      (w_dir),
    .flag     (wr_full)
  );

  afq_side #(.ADDR_W(ADDR_W), .WRITE_SIDE(1'b0)) u_rside (
    .clk      (rd_clk),
    .rst      (rd_rst),
    .req      (rd_en),
    .far_gray (w_gray_s),
    .bin      (r_bin),
    .gray     (r_gray),
    .adv      (r_adv),
    .dir      (r_dir),
    .flag     (rd_empty)
  );

  afq_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk (rd_clk),
    .rst (rd_rst),
    .d   (w_gray),
    .q   (w_gray_s)
  );

  afq_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk (wr_clk),
    .rst (wr_rst),
    .d   (r_gray),
    .q   (r_gray_s)
  );

  afq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk  (wr_clk),
    .we    (w_adv),
    .waddr (w_bin),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .re    (r_adv),
    .raddr (r_bin),
    .rdata (rd_data)
  );

endmodule

// File: rtl/afq_checker.sv
module afq_checker
  import afq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_en,
  input logic              wr_full,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en,
  input logic              rd_empty,
  input logic [ADDR_W-1:0] w_bin,
  input logic [ADDR_W-1:0] w_gray,
  input logic [ADDR_W-1:0] r_bin,
  input logic [ADDR_W-1:0] r_gray,
  input dir_e              w_dir,
  input dir_e              r_dir
);

  p_reset_full_r1: assert property (@(posedge wr_clk)
    wr_rst |=> !wr_full);

  p_reset_empty_r1: assert property (@(posedge rd_clk)
    rd_rst |=> rd_empty);

  p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_full && wr_en) |=> $stable(w_bin));

  p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_empty && rd_en) |=> $stable(r_bin));

  p_gray_step_w_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !$past(wr_rst) |-> ($countones(w_gray ^ $past(w_gray)) <= 1));

  p_gray_step_r_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !$past(rd_rst) |-> ($countones(r_gray ^ $past(r_gray)) <= 1));

  p_full_dir_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_full |-> (w_dir == DIR_FILL));

  p_empty_dir_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_empty |-> (r_dir == DIR_DRAIN));

endmodule

bind async_fifo_qdir afq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst   (wr_rst),
  .wr_en    (wr_en),
  .wr_full  (wr_full),
  .rd_clk   (rd_clk),
  .rd_rst   (rd_rst),
  .rd_en    (rd_en),
  .rd_empty (rd_empty),
  .w_bin    (w_bin),
  .w_gray   (w_gray),
  .r_bin    (r_bin),
  .r_gray   (r_gray),
  .w_dir    (w_dir),
  .r_dir    (r_dir)
);

// File: tb/async_fifo_qdir_tb.sv
module async_fifo_qdir_tb;

  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NSTREAM = 1200;

  // Phase table: writes, then reads, then settle; expected flags afterwards
  localparam int NPH = 8;
  localparam int PH_W [NPH] = '{5, 11, 3, 0, 0, 12, 12, 0};
  localparam int PH_R [NPH] = '{0, 0, 0, 16, 2, 4, 0, 16};
  localparam bit PH_F [NPH] = '{0, 1, 1, 0, 0, 0, 1, 0};
  localparam bit PH_E [NPH] = '{0, 0, 0, 1, 1, 0, 0, 1};

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst = 1'b1;
  logic          rd_rst = 1'b1;
  logic          wr_en  = 1'b0;
  logic          rd_en  = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full;
  logic          rd_empty;

  always #10 wr_clk = ~wr_clk;   // 50 MHz
  always #13 rd_clk = ~rd_clk;   // unrelated read clock

  async_fifo_qdir #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_full  (wr_full),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_empty (rd_empty)
  );

  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] seq = '0;
  bit            acc_w, acc_r;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wpush(input logic [DW-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_data = d;
    wr_en   = 1'b1;
    acc     = !wr_full;
    @(negedge wr_clk);
    wr_en = 1'b0;
    if (acc) model.push_back(d);
  endtask

  task automatic rpop(input string rq, output bit acc);
    logic [DW-1:0] prev, exp;
    @(negedge rd_clk);
    rd_en = 1'b1;
    acc   = !rd_empty;
    prev  = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (acc) begin
      exp = model.pop_front();
      chk(rd_data === exp, rq, int'(rd_data), int'(exp));
    end else begin
      chk(rd_data === prev, "R5 ignored read kept rd_data", int'(rd_data), int'(prev));
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic do_reset();
    @(negedge wr_clk); wr_rst = 1'b1;
    @(negedge rd_clk); rd_rst = 1'b1;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk); wr_rst = 1'b0;
    @(negedge rd_clk); rd_rst = 1'b0;
    model.delete();
    settle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : main
    // R1: reset state
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk); wr_rst = 1'b0;
    @(negedge rd_clk); rd_rst = 1'b0;
    chk(wr_full == 1'b0, "R1 full after reset", int'(wr_full), 0);
    chk(rd_empty == 1'b1, "R1 empty after reset", int'(rd_empty), 1);
    settle();

    // Table-driven phases
    for (int p = 0; p < NPH; p++) begin
      for (int i = 0; i < PH_W[p]; i++) begin
        wpush(seq, acc_w);
        if (acc_w) seq++;
      end
      settle();
      for (int i = 0; i < PH_R[p]; i++) rpop("R2 phase data order", acc_r);
      settle();
      chk(wr_full == PH_F[p], "R3 R4 R7 full after phase", int'(wr_full), int'(PH_F[p]));
      chk(rd_empty == PH_E[p], "R5 R7 empty after phase", int'(rd_empty), int'(PH_E[p]));
      chk(model.size() == (PH_F[p] ? DEPTH : model.size()), "R4 occupancy at full",
          model.size(), DEPTH);
    end

    // R3: full rises at the edge taking the last free slot
    for (int i = 0; i < DEPTH - 1; i++) begin
      wpush(seq, acc_w);
      if (acc_w) seq++;
    end
    chk(wr_full == 1'b0, "R3 not full one short", int'(wr_full), 0);
    wpush(seq, acc_w);
    if (acc_w) seq++;
    chk(wr_full == 1'b1, "R3 full on filling edge", int'(wr_full), 1);

    // R4: write while full is refused and stores nothing (order checked on drain)
    wpush(8'hEE, acc_w);
    chk(acc_w == 1'b0, "R4 write refused while full", int'(acc_w), 0);
    settle();

    // R8: full released after one read
    rpop("R2 first after full", acc_r);
    begin
      int wait_n = 0;
      while (wr_full && wait_n < 12) begin
        @(negedge wr_clk);
        wait_n++;
      end
      chk(wait_n <= 10, "R8 full release latency", wait_n, 10);
    end

    // R5: empty rises at the edge taking the last word
    for (int i = 0; i < DEPTH - 1; i++) rpop("R2 drain after full", acc_r);
    chk(rd_empty == 1'b1, "R5 empty on draining edge", int'(rd_empty), 1);
    rpop("R5 read while empty", acc_r);
    chk(acc_r == 1'b0, "R5 read refused while empty", int'(acc_r), 0);

    // R8: empty released after one write
    wpush(seq, acc_w);
    if (acc_w) seq++;
    begin
      int wait_n = 0;
      while (rd_empty && wait_n < 12) begin
        @(negedge rd_clk);
        wait_n++;
      end
      chk(wait_n <= 10, "R8 empty release latency", wait_n, 10);
    end
    rpop("R2 single word", acc_r);
    settle();

    // R9 with R6: concurrent streaming, many ring wraps, pointers crossing domains
    fork
      begin : writer
        int sent = 0;
        bit a;
        while (sent < NSTREAM) begin
          if ((sent % 7) == 3) @(negedge wr_clk);
          wpush(seq, a);
          if (a) begin
            seq++;
            sent++;
          end
        end
      end
      begin : reader
        int got = 0;
        bit a;
        while (got < NSTREAM) begin
          if ((got % 5) == 2) @(negedge rd_clk);
          rpop("R2 R6 R9 stream order", a);
          if (a) got++;
        end
      end
    join
    settle();
    chk(model.size() == 0, "R9 nothing left after stream", model.size(), 0);
    chk(rd_empty == 1'b1, "R9 empty after stream", int'(rd_empty), 1);

    // R1: reset while holding data
    for (int i = 0; i < 3; i++) begin
      wpush(seq, acc_w);
      if (acc_w) seq++;
    end
    settle();
    do_reset();
    chk(wr_full == 1'b0, "R1 full after mid-run reset", int'(wr_full), 0);
    chk(rd_empty == 1'b1, "R1 empty after mid-run reset", int'(rd_empty), 1);
    wpush(8'h5A, acc_w);
    settle();
    rpop("R1 first word after reset", acc_r);
    chk(acc_r == 1'b1, "R1 read accepted after reset", int'(acc_r), 1);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge wr_clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule